// File: doc/BRIEF.md
# Serial Port Register Bank with Divisor Latch

This block is the host-facing register set of an asynchronous serial port. A host reaches eight byte-wide offsets through an address, a write strobe and a read strobe. Read data is combinational from the current address. Register writes take effect at the clock edge that samples the write strobe. The shift engine and its buffers sit outside this block. They deliver receive data and status levels, and they pulse an input for each error event.

A divisor-access bit in the line control byte changes the meaning of offsets 0 and 1. When the bit is set, those offsets reach the two halves of a 16-bit baud divisor. When it is clear, they reach the data path and the interrupt-enable bits. The line control byte is decoded continuously into word length, stop length, parity mode and break for the serial engine. Modem control bits drive output pins. Line status and modem status gather the engine flags and the four modem input levels. Both keep sticky event bits that a read of that register clears.

Top module: `sio_regfile`

## Requirements
- R1: After reset, the divisor, line control, modem control, interrupt enable and scratch byte are all zero. All decoded outputs reflect those zero values, so data_bits_o=5, stop_halves_o=2, parity off and break off.
- R2: When line control bit 7 is set, a write to offset 0 loads divisor bits 7:0 and a write to offset 1 loads divisor bits 15:8. Reads of those offsets return the same bytes. divisor_o presents the whole 16-bit value, and the baud rate is the reference rate divided by that value.
- R3: When line control bit 7 is clear, the following hold. A write to offset 0 pulses tx_push_o with tx_data_o equal to the written byte, in the same cycle as the write. A read of offset 0 returns rx_data_i and pulses rx_pop_o. Offset 1 holds the 4-bit interrupt enable (ier_o), and its upper read bits are 0. With bit 7 set, neither pulse occurs.
- R4: data_bits_o equals 5 plus line control bits 1:0.
- R5: stop_halves_o gives the stop length in half-bit units. It is 2 when line control bit 2 is clear. When bit 2 is set, it is 3 if bits 1:0 are 00 and 4 otherwise.
- R6: parity_en_o follows line control bit 3. parity_mode_o follows bits 5:4, with 00 for odd, 01 for even, 10 for forced high and 11 for forced low.
- R7: break_o follows line control bit 6.
- R8: Modem control bits 0 to 4 drive dtr_o, rts_o, out1_o, out2_o and loopback_o. Offset 4 reads back those five bits, with bits 7:5 as 0.
- R9: Offset 5 reads line status. Bit 0 is rx_avail_i. Bits 1 to 4 are sticky flags for overrun, parity, framing and break. Bit 5 is thr_empty_i, bit 6 is tx_idle_i and bit 7 is fifo_err_i. A flag is set one clock after its event pulse. A read of offset 5 clears the sticky flags, but an event in the same cycle as the read wins.
- R10: Offset 6 reads modem status. Bits 4 to 7 are the registered levels of CTS, DSR, RI and DCD. Bits 0 to 3 are sticky change flags for the same four signals. A change flag is set when an input differs from its registered level. A read of offset 6 clears the change flags, but a change in the same cycle as the read wins.
- R11: Offset 7 is a scratch byte that reads back what was written and has no side effects. Offset 2 reads 0 and ignores writes.
- R12: Writing 0x83 to offset 3, then 14 to offset 0, then 0 to offset 1, then 0x03 to offset 3 leaves divisor 14 with 8 data bits, 2 stop halves and parity off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data for addr_i |
| tx_push_o | output | 1 | Transmit byte accepted |
| tx_data_o | output | 8 | Transmit byte |
| rx_pop_o | output | 1 | Receive byte consumed |
| rx_data_i | input | 8 | Receive byte from engine |
| rx_avail_i | input | 1 | Receive data present |
| thr_empty_i | input | 1 | Transmit holding empty |
| tx_idle_i | input | 1 | Transmitter fully idle |
| fifo_err_i | input | 1 | Error somewhere in receive buffer |
| overrun_i | input | 1 | Overrun event pulse |
| parity_err_i | input | 1 | Parity error event pulse |
| framing_err_i | input | 1 | Framing error event pulse |
| break_det_i | input | 1 | Break received event pulse |
| cts_i | input | 1 | Clear-to-send level |
| dsr_i | input | 1 | Data-set-ready level |
| ri_i | input | 1 | Ring indicator level |
| dcd_i | input | 1 | Carrier detect level |
| divisor_o | output | 16 | Baud divisor |
| data_bits_o | output | 4 | Word length 5..8 |
| stop_halves_o | output | 3 | Stop length in half bits |
| parity_en_o | output | 1 | Parity enabled |
| parity_mode_o | output | 2 | Parity kind |
| break_o | output | 1 | Force break on line |
| ier_o | output | 4 | Interrupt enable bits |
| dtr_o | output | 1 | Data terminal ready |
| rts_o | output | 1 | Request to send |
| out1_o | output | 1 | Auxiliary output 1 |
| out2_o | output | 1 | Auxiliary output 2 |
| loopback_o | output | 1 | Loopback enable |

## Verification
The assertions assume that the modem inputs and event pulses are already synchronous to clk_i. They also assume that these inputs are low while reset is asserted, so that reset leaves no spurious change flag. The bench drives every input only at the falling edge. It holds all of them at zero through reset. It then applies random and directed patterns in which the event pulses, the modem toggles and the status reads overlap, so that the set-wins-over-clear cases occur.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DW    = 8;
  localparam int AW    = 3;
  localparam int NREGS = 1 << AW;
  localparam int NERR  = 4;
  localparam int NMDM  = 4;

  typedef enum logic [AW-1:0] {
    OFS_DATA = 3'd0,
    OFS_IEN  = 3'd1,
    OFS_RSV  = 3'd2,
    OFS_LCTL = 3'd3,
    OFS_MCTL = 3'd4,
    OFS_LSTS = 3'd5,
    OFS_MSTS = 3'd6,
    OFS_SCR  = 3'd7
  } sio_ofs_e;

  typedef enum logic [1:0] {
    PAR_ODD  = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_HIGH = 2'b10,
    PAR_LOW  = 2'b11
  } sio_par_e;
endpackage

// File: rtl/sio_lctl_decode.sv
module sio_lctl_decode
  import sio_pkg::*;
(
  input  logic [DW-1:0] lctl_i,
  output logic [3:0]    data_bits_o,
  output logic [2:0]    stop_halves_o,
  output logic          parity_en_o,
  output sio_par_e      parity_mode_o,
  output logic          break_o
);
  always_comb begin
    data_bits_o = 4'd5 + {2'b00, lctl_i[1:0]};
    if (!lctl_i[2])               stop_halves_o = 3'd2;
    else if (lctl_i[1:0] == 2'b00) stop_halves_o = 3'd3;
    else                          stop_halves_o = 3'd4;
    parity_en_o   = lctl_i[3];
    parity_mode_o = sio_par_e'(lctl_i[5:4]);
    break_o       = lctl_i[6];
  end

  // R5: stop length stays within 1..2 bits
  always_comb begin
    a_stop_range_r5: assert (stop_halves_o >= 3'd2 && stop_halves_o <= 3'd4);
  end
endmodule

// File: rtl/sio_sticky_bank.sv
module sio_sticky_bank #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[g] <= 1'b0;
      else if (set_i[g]) flag_o[g] <= 1'b1;
      else if (clr_i)    flag_o[g] <= 1'b0;
    end

    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[g] && !clr_i) |=> flag_o[g]);
    p_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_o[g]);
  end
endmodule

// File: rtl/sio_modem_track.sv
module sio_modem_track #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic         clr_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] chg_o
);
  logic [N-1:0] diff;
  assign diff = pin_i ^ lvl_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_o <= '0;
    else         lvl_o <= pin_i;
  end

  sio_sticky_bank #(.N(N)) u_chg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (diff),
    .clr_i  (clr_i),
    .flag_o (chg_o)
  );

  p_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && diff == '0) |=> (chg_o == '0));
  p_lvl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diff == '0) |=> $stable(lvl_o));
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
  import sio_pkg::*;
#(
  parameter int IEN_W = 4,
  parameter int MCR_W = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          tx_push_o,
  output logic [DW-1:0] tx_data_o,
  output logic          rx_pop_o,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_avail_i,
  input  logic          thr_empty_i,
  input  logic          tx_idle_i,
  input  logic          fifo_err_i,
  input  logic          overrun_i,
  input  logic          parity_err_i,
  input  logic          framing_err_i,
  input  logic          break_det_i,
  input  logic          cts_i,
  input  logic          dsr_i,
  input  logic          ri_i,
  input  logic          dcd_i,
  output logic [2*DW-1:0] divisor_o,
  output logic [3:0]    data_bits_o,
  output logic [2:0]    stop_halves_o,
  output logic          parity_en_o,
  output logic [1:0]    parity_mode_o,
  output logic          break_o,
  output logic [IEN_W-1:0] ier_o,
  output logic          dtr_o,
  output logic          rts_o,
  output logic          out1_o,
  output logic          out2_o,
  output logic          loopback_o
);
  localparam int DIV_W = 2 * DW;

  logic [DW-1:0]    lctl_q, scr_q, dll_q, dlm_q;
  logic [MCR_W-1:0] mctl_q;
  logic [IEN_W-1:0] ien_q;
  logic [NREGS-1:0] sel;
  logic             dlab;
  logic [NERR-1:0]  err_flags;
  logic [NMDM-1:0]  mdm_lvl, mdm_chg;
  sio_par_e         par_mode;

  for (genvar g = 0; g < NREGS; g++) begin : g_sel
    assign sel[g] = (addr_i == AW'(g));
  end

  assign dlab = lctl_q[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lctl_q <= '0;
      mctl_q <= '0;
      ien_q  <= '0;
      scr_q  <= '0;
      dll_q  <= '0;
      dlm_q  <= '0;
    end else if (wr_i) begin
      if (sel[OFS_DATA] && dlab)  dll_q  <= wdata_i;
      if (sel[OFS_IEN] && dlab)   dlm_q  <= wdata_i;
      if (sel[OFS_IEN] && !dlab)  ien_q  <= wdata_i[IEN_W-1:0];
      if (sel[OFS_LCTL])          lctl_q <= wdata_i;
      if (sel[OFS_MCTL])          mctl_q <= wdata_i[MCR_W-1:0];
      if (sel[OFS_SCR])           scr_q  <= wdata_i;
    end
  end

  assign divisor_o = {dlm_q, dll_q};
  assign ier_o     = ien_q;
  assign tx_push_o = wr_i && sel[OFS_DATA] && !dlab;
  assign tx_data_o = wdata_i;
  assign rx_pop_o  = rd_i && sel[OFS_DATA] && !dlab;
  assign {loopback_o, out2_o, out1_o, rts_o, dtr_o} = mctl_q;

  sio_lctl_decode u_dec (
    .lctl_i        (lctl_q),
    .data_bits_o   (data_bits_o),
    .stop_halves_o (stop_halves_o),
    .parity_en_o   (parity_en_o),
    .parity_mode_o (par_mode),
    .break_o       (break_o)
  );
  assign parity_mode_o = par_mode;

  sio_sticky_bank #(.N(NERR)) u_lsts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({break_det_i, framing_err_i, parity_err_i, overrun_i}),
    .clr_i  (rd_i && sel[OFS_LSTS]),
    .flag_o (err_flags)
  );

  sio_modem_track #(.N(NMDM)) u_msts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({dcd_i, ri_i, dsr_i, cts_i}),
    .clr_i  (rd_i && sel[OFS_MSTS]),
    .lvl_o  (mdm_lvl),
    .chg_o  (mdm_chg)
  );

  always_comb begin
    rdata_o = '0;
    unique case (sio_ofs_e'(addr_i))
      OFS_DATA: rdata_o = dlab ? dll_q : rx_data_i;
      OFS_IEN:  rdata_o = dlab ? dlm_q : DW'(ien_q);
      OFS_RSV:  rdata_o = '0;
      OFS_LCTL: rdata_o = lctl_q;
      OFS_MCTL: rdata_o = DW'(mctl_q);
      OFS_LSTS: rdata_o = {fifo_err_i, tx_idle_i, thr_empty_i, err_flags, rx_avail_i};
      OFS_MSTS: rdata_o = {mdm_lvl, mdm_chg};
      OFS_SCR:  rdata_o = scr_q;
      default:  rdata_o = '0;
    endcase
  end

  p_div_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && dlab && (sel[OFS_DATA] || sel[OFS_IEN])) |=> $stable(divisor_o));
  p_no_push_dlab_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push_o || rx_pop_o) |-> !lctl_q[DW-1]);
  p_mctl_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel[OFS_MCTL]) |=> $stable({loopback_o, out2_o, out1_o, rts_o, dtr_o}));
  p_scr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel[OFS_SCR]) |=> $stable(scr_q));
  p_brk_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel[OFS_LCTL]) |=> (break_o == $past(wdata_i[6])));
endmodule

// File: tb/sio_regfile_tb.sv
module sio_regfile_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] a = '0;
  logic [7:0] w = '0, rxd = '0;
  logic we = 0, re = 0, rxv = 0, the = 0, txi = 0, fe = 0;
  logic [3:0] ev = '0, mdm = '0;

  logic [7:0] rdata, txd;
  logic txp, rxp, pen, brk, dtr, rts, o1, o2, lb;
  logic [15:0] div;
  logic [3:0] dbits, ier;
  logic [2:0] stops;
  logic [1:0] pmode;

  int checks = 0, fails = 0;
  int m_lctl = 0, m_mctl = 0, m_ier = 0, m_scr = 0, m_dll = 0, m_dlm = 0;
  int m_st[4] = '{0, 0, 0, 0};
  int m_lv[4] = '{0, 0, 0, 0};
  int m_ch[4] = '{0, 0, 0, 0};

  always #(CLK_PERIOD / 2) clk = ~clk;

  sio_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(a), .wdata_i(w), .wr_i(we), .rd_i(re),
    .rdata_o(rdata), .tx_push_o(txp), .tx_data_o(txd), .rx_pop_o(rxp),
    .rx_data_i(rxd), .rx_avail_i(rxv), .thr_empty_i(the), .tx_idle_i(txi),
    .fifo_err_i(fe), .overrun_i(ev[0]), .parity_err_i(ev[1]),
    .framing_err_i(ev[2]), .break_det_i(ev[3]),
    .cts_i(mdm[0]), .dsr_i(mdm[1]), .ri_i(mdm[2]), .dcd_i(mdm[3]),
    .divisor_o(div), .data_bits_o(dbits), .stop_halves_o(stops),
    .parity_en_o(pen), .parity_mode_o(pmode), .break_o(brk), .ier_o(ier),
    .dtr_o(dtr), .rts_o(rts), .out1_o(o1), .out2_o(o2), .loopback_o(lb)
  );

  task automatic chk(string tag, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, name, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata();
    int dl = (m_lctl >> 7) & 1;
    case (a)
      0: return dl ? m_dll : rxd;
      1: return dl ? m_dlm : m_ier;
      3: return m_lctl;
      4: return m_mctl;
      5: return (fe << 7) | (txi << 6) | (the << 5) | (m_st[3] << 4) | (m_st[2] << 3)
              | (m_st[1] << 2) | (m_st[0] << 1) | rxv;
      6: return (m_lv[3] << 7) | (m_lv[2] << 6) | (m_lv[1] << 5) | (m_lv[0] << 4)
              | (m_ch[3] << 3) | (m_ch[2] << 2) | (m_ch[1] << 1) | m_ch[0];
      7: return m_scr;
      default: return 0;
    endcase
  endfunction

  function automatic string rtag();
    case (a)
      0, 1: return ((m_lctl >> 7) & 1) ? "R2" : "R3";
      3: return "R4";
      4: return "R8";
      5: return "R9";
      6: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic compare();
    int dl = (m_lctl >> 7) & 1;
    int lc = m_lctl & 3;
    int sh = ((m_lctl >> 2) & 1) == 0 ? 2 : (lc == 0 ? 3 : 4);
    chk(rtag(), "rdata", rdata, exp_rdata());
    chk("R2", "divisor", div, m_dlm * 256 + m_dll);
    chk("R3", "tx_push", txp, (we && a == 0 && !dl) ? 1 : 0);
    if (txp) chk("R3", "tx_data", txd, w);
    chk("R3", "rx_pop", rxp, (re && a == 0 && !dl) ? 1 : 0);
    chk("R3", "ier", ier, m_ier);
    chk("R4", "data_bits", dbits, 5 + lc);
    chk("R5", "stop_halves", stops, sh);
    chk("R6", "parity_en", pen, (m_lctl >> 3) & 1);
    chk("R6", "parity_mode", pmode, (m_lctl >> 4) & 3);
    chk("R7", "break", brk, (m_lctl >> 6) & 1);
    chk("R8", "mctl_pins", {lb, o2, o1, rts, dtr}, m_mctl);
  endtask

  task automatic model_edge();
    int dl = (m_lctl >> 7) & 1;
    bit lclr = re && a == 5;
    bit mclr = re && a == 6;
    for (int i = 0; i < 4; i++) begin
      m_st[i] = (ev[i] || (m_st[i] && !lclr)) ? 1 : 0;
      m_ch[i] = ((mdm[i] != m_lv[i]) || (m_ch[i] && !mclr)) ? 1 : 0;
      m_lv[i] = mdm[i];
    end
    if (we) begin
      case (a)
        0: if (dl) m_dll = w;
        1: if (dl) m_dlm = w; else m_ier = w & 15;
        3: m_lctl = w;
        4: m_mctl = w & 31;
        7: m_scr = w;
        default: ;
      endcase
    end
  endtask

  task automatic cyc(int ad, bit wr, bit rd, int wd);
    a = 3'(ad); we = wr; re = rd; w = 8'(wd);
    #1;
    compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    we = 0; re = 0; ev = '0;
  endtask

  task automatic wr_reg(int ad, int wd); cyc(ad, 1, 0, wd); endtask
  task automatic rd_reg(int ad);         cyc(ad, 0, 1, 0);  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "divisor_reset", div, 0);
    chk("R1", "data_bits_reset", dbits, 5);
    chk("R1", "stop_reset", stops, 2);
    chk("R1", "pins_reset", {lb, o2, o1, rts, dtr, pen, brk}, 0);
    a = 3; #1; chk("R1", "lctl_reset", rdata, 0);
    a = 7; #1; chk("R1", "scr_reset", rdata, 0);
    @(negedge clk);

    // R12: init sequence for 8N1 with divisor 14
    wr_reg(3, 8'h83); wr_reg(0, 14); wr_reg(1, 0);
    rd_reg(0); rd_reg(1);
    wr_reg(3, 8'h03);
    chk("R12", "init_divisor", div, 14);
    chk("R12", "init_bits", dbits, 8);
    chk("R12", "init_stops", stops, 2);
    chk("R12", "init_parity", pen, 0);

    // R2: full divisor extremes, data path blocked
    wr_reg(3, 8'h80); wr_reg(0, 8'hFF); wr_reg(1, 8'hFF); rd_reg(0);
    wr_reg(0, 1); wr_reg(1, 0); rd_reg(1);
    // R3: data path, IER
    wr_reg(3, 0); rxd = 8'hA5; rd_reg(0); wr_reg(0, 8'h3C);
    wr_reg(1, 8'hFF); rd_reg(1); wr_reg(1, 8'h05); rd_reg(1);
    chk("R3", "divisor_kept", div, 1);

    // R4..R7: every line control pattern with bit 7 clear
    for (int i = 0; i < 128; i++) begin
      wr_reg(3, i); rd_reg(3);
    end
    wr_reg(3, 0);

    // R8 modem control; R11 scratch and reserved
    for (int i = 0; i < 40; i++) begin
      wr_reg(4, $urandom_range(0, 255)); rd_reg(4);
      wr_reg(7, $urandom_range(0, 255)); rd_reg(7);
      wr_reg(2, 8'hFF); rd_reg(2);
    end

    // R9: sticky error flags with set-vs-clear overlap
    the = 1; txi = 1; rxv = 1; fe = 0;
    ev = 4'b0101; cyc(5, 0, 0, 0); rd_reg(5); rd_reg(5);
    ev = 4'b1010; rd_reg(5); rd_reg(5); rd_reg(5);
    for (int i = 0; i < 200; i++) begin
      ev = 4'($urandom_range(0, 15)) & {4{$urandom_range(0, 3) == 0}};
      {fe, txi, the, rxv} = 4'($urandom_range(0, 15));
      cyc(5, 0, $urandom_range(0, 3) == 0, 0);
    end

    // R10: modem status change tracking
    mdm = 4'b0001; rd_reg(6); rd_reg(6); rd_reg(6);
    mdm = 4'b1000; rd_reg(6); rd_reg(6);
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 2) == 0) mdm = 4'($urandom_range(0, 15));
      cyc(6, 0, $urandom_range(0, 3) == 0, 0);
    end

    // mixed random traffic across all offsets
    for (int i = 0; i < 2000; i++) begin
      rxd = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 4) == 0) mdm = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 4) == 0) ev = 4'($urandom_range(0, 15));
      cyc($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 1),
          $urandom_range(0, 255));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule